// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside the fetch and decode stages of a processor core and decides, once per clock, whether the core must leave its current flow. It takes a held debug request, trigger hits, decoded ebreak, ecall, mret and dret strobes, an exception strobe, and NMI and interrupt requests. From these it picks one event by fixed priority. The result is a single redirect of fetch to the proper target, together with the state writes that go with that event.

Outside debug mode, the controller can enter debug mode. On entry it saves the current PC as the debug PC and records a cause code. It can also send the core to its ordinary trap or NMI vector, and it tells the CSR file that the machine trap registers must be updated. Inside debug mode, the only events that count are the core's own control instructions and exceptions. Each one sends fetch back to one of two fixed debug-program addresses and writes no CSR. A dret leaves debug mode and resumes at the saved debug PC.

The controller keeps its own copy of the dcsr bit that lets a machine-mode ebreak enter debug mode. That bit can be written only in debug mode. A debug-register access made outside debug mode is flagged as illegal.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While rst is high and in the first cycle after it, every output is 0: no redirect, no writes, not in debug mode, ebreakm_o low, illegal_o low.
- R2: Outside debug mode, a debug entry gives these results one cycle after the request is sampled: redir_o pulses, redir_pc_o equals halt_addr_i with bits [1:0] forced to 0, dpc_we_o pulses with dpc_wdata_o equal to pc_i, and dbg_mode_o rises.
- R3: A debug entry is caused by any of three sources: trig_hit_i together with trig_act_i=1, ebreak_i while ebreakm_o=1, or halt_req_i. cause_we_o pulses together with dpc_we_o. cause_o is 2 for a trigger, 1 for ebreak and 3 for a halt request. If several sources are present, the trigger wins, then ebreak, then the halt request. A trigger hit with trig_act_i=0 causes no entry.
- R4: Outside debug mode, ebreak_i while ebreakm_o=0 does not enter debug mode. It redirects to mtvec_i with trap_we_o=1 and trap_code_o=1.
- R5: Outside debug mode, events are ranked in this order: NMI, then debug entry, then interrupt, then breakpoint, then exception or ecall. An NMI redirects to nmi_addr_i with trap code 3. An interrupt and an exception or ecall redirect to mtvec_i with trap codes 2 and 0.
- R6: Inside debug mode, ebreak_i redirects to halt_addr_i (bits [1:0] cleared). It raises no dpc, cause or trap write.
- R7: Inside debug mode, exc_i, ecall_i or mret_i redirect to exc_addr_i (bits [1:0] cleared). This takes priority over ebreak_i and raises no dpc, cause or trap write.
- R8: Inside debug mode, dret_i has the highest priority. It redirects to the PC saved at the last entry and clears dbg_mode_o. Outside debug mode, dret_i has no effect.
- R9: Inside debug mode, halt_req_i, trigger hits, nmi_i and irq_i have no effect.
- R10: redir_o is never high on two consecutive cycles. All events sampled in the cycle right after a redirect is issued are discarded.
- R11: ebreakm_o resets to 0. It takes ebreakm_wdata_i on ebreakm_we_i only while in debug mode. A csr_acc_i sampled outside debug mode raises illegal_o on the next cycle.
- R12: Outside debug mode, mret_i alone causes no redirect and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Level-sensitive external debug request |
| trig_hit_i | input | 1 | Trigger match this cycle |
| trig_act_i | input | 1 | Action field of the matching trigger (1 = enter debug) |
| ebreak_i | input | 1 | Decoded ebreak strobe |
| ecall_i | input | 1 | Decoded ecall strobe |
| mret_i | input | 1 | Decoded mret strobe |
| exc_i | input | 1 | Synchronous exception strobe |
| dret_i | input | 1 | Decoded dret strobe |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | 1 | Ordinary interrupt request |
| csr_acc_i | input | 1 | Access to a debug CSR this cycle |
| ebreakm_we_i | input | 1 | Write enable for the ebreak-to-debug bit |
| ebreakm_wdata_i | input | 1 | Write data for the ebreak-to-debug bit |
| pc_i | input | XLEN | PC of the current instruction |
| halt_addr_i | input | XLEN | Debug halt entry address |
| exc_addr_i | input | XLEN | Debug exception entry address |
| mtvec_i | input | XLEN | Ordinary trap vector |
| nmi_addr_i | input | XLEN | NMI vector |
| redir_o | output | 1 | Single-cycle redirect strobe |
| redir_pc_o | output | XLEN | Redirect target |
| dpc_we_o | output | 1 | Debug PC write strobe |
| dpc_wdata_o | output | XLEN | Debug PC write value |
| cause_we_o | output | 1 | dcsr cause write strobe |
| cause_o | output | 3 | dcsr cause value |
| trap_we_o | output | 1 | Machine trap CSR update strobe |
| trap_code_o | output | 2 | Trap kind: 0 exception, 1 breakpoint, 2 interrupt, 3 NMI |
| dbg_mode_o | output | 1 | Core is in debug mode |
| ebreakm_o | output | 1 | Current ebreak-to-debug bit |
| illegal_o | output | 1 | Debug CSR accessed outside debug mode |

## Verification
Every result of this block is registered once, so each redirect, write strobe, cause, trap code, mode change, ebreakm update and illegal flag is due exactly one rising edge after the inputs that caused it. The bench drives inputs on the falling edge. Before the rising edge it computes what the next output set must be from its own model of mode, flush, debug PC and ebreakm. It then samples all outputs at the following falling edge. This timing also covers the cycle right after a redirect, in which any stimulus must leave the outputs idle.

// File: rtl/dbgent_pkg.sv
package dbgent_pkg;

    localparam int CAUSE_W = 3;
    localparam int TRAP_W  = 2;

    // dcsr cause codes
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_EBREAK  = 3'd1,
        CAUSE_TRIGGER = 3'd2,
        CAUSE_HALTREQ = 3'd3
    } cause_e;

    // trap kinds reported for mepc/mcause update
    typedef enum logic [TRAP_W-1:0] {
        TRAP_EXC = 2'd0,
        TRAP_BRK = 2'd1,
        TRAP_IRQ = 2'd2,
        TRAP_NMI = 2'd3
    } trap_e;

    // selected event of a cycle
    typedef enum logic [2:0] {
        EV_NONE,
        EV_NMI,
        EV_ENTER,
        EV_IRQ,
        EV_TRAP,
        EV_DRET,
        EV_DM_HALT,
        EV_DM_EXC
    } ev_e;

    typedef struct packed {
        logic halt_req;
        logic trig_fire;
        logic ebreak;
        logic ecall;
        logic mret;
        logic exc;
        logic dret;
        logic nmi;
        logic irq;
    } req_t;

    typedef struct packed {
        ev_e    ev;
        cause_e cause;
        trap_e  trap;
    } dec_t;

    // trigger beats ebreak beats halt request
    function automatic cause_e pick_cause(logic trig, logic brk, logic halt);
        if (trig)      return CAUSE_TRIGGER;
        else if (brk)  return CAUSE_EBREAK;
        else if (halt) return CAUSE_HALTREQ;
        else           return CAUSE_NONE;
    endfunction

    function automatic logic ev_writes_trap(ev_e ev);
        return (ev == EV_NMI) || (ev == EV_IRQ) || (ev == EV_TRAP);
    endfunction

    function automatic logic ev_writes_dbg(ev_e ev);
        return ev == EV_ENTER;
    endfunction

endpackage

// File: rtl/dbgent_arb.sv
module dbgent_arb
    import dbgent_pkg::*;
(
    input  req_t req,
    input  logic mode,
    input  logic flush,
    input  logic ebreakm,
    output dec_t dec
);

    logic brk_dbg;
    logic enter;
    logic dm_exc;

    assign brk_dbg = req.ebreak & ebreakm;
    assign enter   = req.trig_fire | brk_dbg | req.halt_req;
    assign dm_exc  = req.exc | req.ecall | req.mret;

    always_comb begin
        dec.ev    = EV_NONE;
        dec.cause = CAUSE_NONE;
        dec.trap  = TRAP_EXC;
        if (!flush) begin
            if (mode) begin
                // only the debug program's own control flow counts here
                if (req.dret) begin
                    dec.ev = EV_DRET;
                end else if (dm_exc) begin
                    dec.ev = EV_DM_EXC;
                end else if (req.ebreak) begin
                    dec.ev = EV_DM_HALT;
                end
            end else begin
                if (req.nmi) begin
                    dec.ev   = EV_NMI;
                    dec.trap = TRAP_NMI;
                end else if (enter) begin
                    dec.ev    = EV_ENTER;
                    dec.cause = pick_cause(req.trig_fire, brk_dbg, req.halt_req);
                end else if (req.irq) begin
                    dec.ev   = EV_IRQ;
                    dec.trap = TRAP_IRQ;
                end else if (req.ebreak) begin
                    dec.ev   = EV_TRAP;
                    dec.trap = TRAP_BRK;
                end else if (req.exc | req.ecall) begin
                    dec.ev   = EV_TRAP;
                    dec.trap = TRAP_EXC;
                end
            end
        end
    end

endmodule

// File: rtl/dbgent_state.sv
module dbgent_state
    import dbgent_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  dec_t            dec,
    input  logic [XLEN-1:0] pc,
    input  logic            csr_acc,
    input  logic            ebm_we,
    input  logic            ebm_wdata,
    output logic            mode_q,
    output logic            flush_q,
    output logic            ebm_q,
    output logic            illegal_q,
    output logic [XLEN-1:0] dpc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 1'b0;
            flush_q   <= 1'b0;
            ebm_q     <= 1'b0;
            illegal_q <= 1'b0;
            dpc_q     <= '0;
        end else begin
            flush_q   <= (dec.ev != EV_NONE);
            illegal_q <= csr_acc & ~mode_q;
            if (ebm_we && mode_q) begin
                ebm_q <= ebm_wdata;
            end
            if (dec.ev == EV_ENTER) begin
                mode_q <= 1'b1;
                dpc_q  <= pc;
            end else if (dec.ev == EV_DRET) begin
                mode_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbgent_tgt.sv
module dbgent_tgt
    import dbgent_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int ALIGN_LSB = 2
) (
    input  ev_e             ev,
    input  logic [XLEN-1:0] halt_addr,
    input  logic [XLEN-1:0] exc_addr,
    input  logic [XLEN-1:0] mtvec,
    input  logic [XLEN-1:0] nmi_addr,
    input  logic [XLEN-1:0] dpc,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] halt_al;
    logic [XLEN-1:0] exc_al;

    generate
        if (ALIGN_LSB > 0) begin : g_align
            localparam logic [XLEN-1:0] MASK = {{(XLEN-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};
            assign halt_al = halt_addr & MASK;
            assign exc_al  = exc_addr & MASK;
        end else begin : g_pass
            assign halt_al = halt_addr;
            assign exc_al  = exc_addr;
        end
    endgenerate

    always_comb begin
        unique case (ev)
            EV_NMI:                 target = nmi_addr;
            EV_ENTER, EV_DM_HALT:   target = halt_al;
            EV_DM_EXC:              target = exc_al;
            EV_IRQ, EV_TRAP:        target = mtvec;
            EV_DRET:                target = dpc;
            default:                target = '0;
        endcase
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbgent_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int ALIGN_LSB = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                halt_req_i,
    input  logic                trig_hit_i,
    input  logic                trig_act_i,
    input  logic                ebreak_i,
    input  logic                ecall_i,
    input  logic                mret_i,
    input  logic                exc_i,
    input  logic                dret_i,
    input  logic                nmi_i,
    input  logic                irq_i,
    input  logic                csr_acc_i,
    input  logic                ebreakm_we_i,
    input  logic                ebreakm_wdata_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     halt_addr_i,
    input  logic [XLEN-1:0]     exc_addr_i,
    input  logic [XLEN-1:0]     mtvec_i,
    input  logic [XLEN-1:0]     nmi_addr_i,
    output logic                redir_o,
    output logic [XLEN-1:0]     redir_pc_o,
    output logic                dpc_we_o,
    output logic [XLEN-1:0]     dpc_wdata_o,
    output logic                cause_we_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic                trap_we_o,
    output logic [TRAP_W-1:0]   trap_code_o,
    output logic                dbg_mode_o,
    output logic                ebreakm_o,
    output logic                illegal_o
);

    req_t            req;
    dec_t            dec;
    logic            mode_q;
    logic            flush_q;
    logic            ebm_q;
    logic            illegal_q;
    logic [XLEN-1:0] dpc_q;
    logic [XLEN-1:0] target;

    assign req.halt_req  = halt_req_i;
    assign req.trig_fire = trig_hit_i & trig_act_i;
    assign req.ebreak    = ebreak_i;
    assign req.ecall     = ecall_i;
    assign req.mret      = mret_i;
    assign req.exc       = exc_i;
    assign req.dret      = dret_i;
    assign req.nmi       = nmi_i;
    assign req.irq       = irq_i;

    dbgent_arb u_arb (
        .req     (req),
        .mode    (mode_q),
        .flush   (flush_q),
        .ebreakm (ebm_q),
        .dec     (dec)
    );

    dbgent_state #(.XLEN(XLEN)) u_state (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .pc        (pc_i),
        .csr_acc   (csr_acc_i),
        .ebm_we    (ebreakm_we_i),
        .ebm_wdata (ebreakm_wdata_i),
        .mode_q    (mode_q),
        .flush_q   (flush_q),
        .ebm_q     (ebm_q),
        .illegal_q (illegal_q),
        .dpc_q     (dpc_q)
    );

    dbgent_tgt #(.XLEN(XLEN), .ALIGN_LSB(ALIGN_LSB)) u_tgt (
        .ev        (dec.ev),
        .halt_addr (halt_addr_i),
        .exc_addr  (exc_addr_i),
        .mtvec     (mtvec_i),
        .nmi_addr  (nmi_addr_i),
        .dpc       (dpc_q),
        .target    (target)
    );

    // registered result stage
    always_ff @(posedge clk) begin
        if (rst) begin
            redir_o     <= 1'b0;
            redir_pc_o  <= '0;
            dpc_we_o    <= 1'b0;
            dpc_wdata_o <= '0;
            cause_we_o  <= 1'b0;
            cause_o     <= '0;
            trap_we_o   <= 1'b0;
            trap_code_o <= '0;
        end else begin
            redir_o     <= (dec.ev != EV_NONE);
            redir_pc_o  <= target;
            dpc_we_o    <= ev_writes_dbg(dec.ev);
            dpc_wdata_o <= ev_writes_dbg(dec.ev) ? pc_i : '0;
            cause_we_o  <= ev_writes_dbg(dec.ev);
            cause_o     <= dec.cause;
            trap_we_o   <= ev_writes_trap(dec.ev);
            trap_code_o <= ev_writes_trap(dec.ev) ? dec.trap : TRAP_EXC;
        end
    end

    assign dbg_mode_o = mode_q;
    assign ebreakm_o  = ebm_q;
    assign illegal_o  = illegal_q;

endmodule

// File: rtl/dbgent_chk.sv
module dbgent_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            redir_o,
    input logic [XLEN-1:0] redir_pc_o,
    input logic            dpc_we_o,
    input logic            cause_we_o,
    input logic [2:0]      cause_o,
    input logic            trap_we_o,
    input logic            dbg_mode_o,
    input logic            ebreakm_o,
    input logic            illegal_o
);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        redir_o |=> !redir_o);

    a_r2_entry_redirects: assert property (@(posedge clk) disable iff (rst)
        dpc_we_o |-> (redir_o && redir_pc_o[1:0] == 2'b00 && cause_we_o));

    a_r2_mode_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_mode_o) |-> (dpc_we_o && redir_o));

    a_r3_cause_code: assert property (@(posedge clk) disable iff (rst)
        cause_we_o |-> (cause_o inside {3'd1, 3'd2, 3'd3}));

    a_r6_no_csr_in_dm: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_o && $past(dbg_mode_o)) |-> (!dpc_we_o && !cause_we_o && !trap_we_o));

    a_r8_dret_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_mode_o) |-> (redir_o && !dpc_we_o && !trap_we_o));

    a_r5_trap_outside: assert property (@(posedge clk) disable iff (rst)
        trap_we_o |-> (redir_o && !dbg_mode_o && !dpc_we_o));

    a_r11_illegal_src: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !$past(dbg_mode_o));

    a_r11_ebm_locked: assert property (@(posedge clk) disable iff (rst)
        !$past(dbg_mode_o) |-> $stable(ebreakm_o));

endmodule

bind dbg_entry_ctrl dbgent_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .redir_o    (redir_o),
    .redir_pc_o (redir_pc_o),
    .dpc_we_o   (dpc_we_o),
    .cause_we_o (cause_we_o),
    .cause_o    (cause_o),
    .trap_we_o  (trap_we_o),
    .dbg_mode_o (dbg_mode_o),
    .ebreakm_o  (ebreakm_o),
    .illegal_o  (illegal_o)
);

// File: tb/dbg_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_tb_top;

    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic halt_req, trig_hit, trig_act, ebreak, ecall, mret, exc, dret, nmi, irq;
    logic csr_acc, ebm_we, ebm_wd;
    logic [XLEN-1:0] pc, halt_addr, exc_addr, mtvec, nmi_addr;

    logic            redir, dpc_we, cause_we, trap_we, dbg_mode, ebm, illegal;
    logic [XLEN-1:0] redir_pc, dpc_wdata;
    logic [2:0]      cause;
    logic [1:0]      trap_code;

    dbg_entry_ctrl #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst(rst),
        .halt_req_i(halt_req), .trig_hit_i(trig_hit), .trig_act_i(trig_act),
        .ebreak_i(ebreak), .ecall_i(ecall), .mret_i(mret), .exc_i(exc),
        .dret_i(dret), .nmi_i(nmi), .irq_i(irq),
        .csr_acc_i(csr_acc), .ebreakm_we_i(ebm_we), .ebreakm_wdata_i(ebm_wd),
        .pc_i(pc), .halt_addr_i(halt_addr), .exc_addr_i(exc_addr),
        .mtvec_i(mtvec), .nmi_addr_i(nmi_addr),
        .redir_o(redir), .redir_pc_o(redir_pc), .dpc_we_o(dpc_we),
        .dpc_wdata_o(dpc_wdata), .cause_we_o(cause_we), .cause_o(cause),
        .trap_we_o(trap_we), .trap_code_o(trap_code), .dbg_mode_o(dbg_mode),
        .ebreakm_o(ebm), .illegal_o(illegal)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model state
    logic m_mode, m_flush, m_ebm;
    logic [XLEN-1:0] m_dpc;
    // expected outputs
    logic e_redir, e_dpc_we, e_cause_we, e_trap_we, e_illegal;
    logic [XLEN-1:0] e_pc, e_dpc;
    logic [2:0] e_cause;
    logic [1:0] e_trap;
    string e_tag;

    function automatic void chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endfunction

    task automatic clear_in();
        {halt_req, trig_hit, trig_act, ebreak, ecall, mret, exc, dret, nmi, irq} = '0;
        {csr_acc, ebm_we, ebm_wd} = '0;
    endtask

    function automatic void model_reset();
        m_mode = 0; m_flush = 0; m_ebm = 0; m_dpc = '0;
        e_redir = 0; e_pc = '0; e_dpc_we = 0; e_dpc = '0; e_cause_we = 0; e_cause = 0;
        e_trap_we = 0; e_trap = 0; e_illegal = 0;
    endfunction

    // expected next-cycle outputs derived from the requirement list
    function automatic void model_step();
        logic [XLEN-1:0] halt_al, exc_al;
        logic trig, enter;
        halt_al = {halt_addr[XLEN-1:2], 2'b00};
        exc_al  = {exc_addr[XLEN-1:2], 2'b00};
        trig  = trig_hit & trig_act;
        enter = trig | (ebreak & m_ebm) | halt_req;
        e_redir = 0; e_pc = '0; e_dpc_we = 0; e_dpc = '0; e_cause_we = 0; e_cause = 0;
        e_trap_we = 0; e_trap = 0;
        e_illegal = csr_acc & ~m_mode;
        e_tag = m_mode ? "R9" : "R12";
        if (m_flush) begin
            e_tag = "R10";
        end else if (m_mode) begin
            if (dret) begin
                e_redir = 1; e_pc = m_dpc; e_tag = "R8";
            end else if (exc | ecall | mret) begin
                e_redir = 1; e_pc = exc_al; e_tag = "R7";
            end else if (ebreak) begin
                e_redir = 1; e_pc = halt_al; e_tag = "R6";
            end
        end else begin
            if (nmi) begin
                e_redir = 1; e_pc = nmi_addr; e_trap_we = 1; e_trap = 3; e_tag = "R5";
            end else if (enter) begin
                e_redir = 1; e_pc = halt_al; e_dpc_we = 1; e_dpc = pc; e_cause_we = 1;
                e_cause = trig ? 3'd2 : ((ebreak & m_ebm) ? 3'd1 : 3'd3);
                e_tag = "R3";
            end else if (irq) begin
                e_redir = 1; e_pc = mtvec; e_trap_we = 1; e_trap = 2; e_tag = "R5";
            end else if (ebreak) begin
                e_redir = 1; e_pc = mtvec; e_trap_we = 1; e_trap = 1; e_tag = "R4";
            end else if (exc | ecall) begin
                e_redir = 1; e_pc = mtvec; e_trap_we = 1; e_trap = 0; e_tag = "R5";
            end
        end
        if (ebm_we && m_mode) m_ebm = ebm_wd;
        if (e_dpc_we) begin m_mode = 1; m_dpc = pc; end
        else if (e_redir && m_mode && dret && !m_flush) m_mode = 0;
        m_flush = e_redir;
    endfunction

    task automatic cyc(string tag);
        string t;
        model_step();
        t = (tag == "") ? e_tag : tag;
        @(posedge clk);
        @(negedge clk);
        cycles++;
        chk(redir === e_redir, t, "redir", redir, e_redir);
        if (e_redir) chk(redir_pc === e_pc, t, "redir_pc", redir_pc, e_pc);
        chk(dpc_we === e_dpc_we, (e_dpc_we ? "R2" : t), "dpc_we", dpc_we, e_dpc_we);
        if (e_dpc_we) chk(dpc_wdata === e_dpc, "R2", "dpc_wdata", dpc_wdata, e_dpc);
        chk(cause_we === e_cause_we, t, "cause_we", cause_we, e_cause_we);
        if (e_cause_we) chk(cause === e_cause, "R3", "cause", cause, e_cause);
        chk(trap_we === e_trap_we, t, "trap_we", trap_we, e_trap_we);
        if (e_trap_we) chk(trap_code === e_trap, t, "trap_code", trap_code, e_trap);
        chk(dbg_mode === m_mode, t, "dbg_mode", dbg_mode, m_mode);
        chk(ebm === m_ebm, "R11", "ebreakm", ebm, m_ebm);
        chk(illegal === e_illegal, "R11", "illegal", illegal, e_illegal);
    endtask

    // one stimulus cycle followed by an idle cycle
    task automatic hit(string tag);
        cyc(tag);
        clear_in();
        cyc(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_0d0e));
        clear_in();
        pc = 32'h0000_1000; halt_addr = 32'h0000_0803; exc_addr = 32'h0000_0812;
        mtvec = 32'h0000_0100; nmi_addr = 32'h0000_0200;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({redir, dpc_we, cause_we, trap_we, dbg_mode, ebm, illegal} === 7'b0, "R1", "reset outputs",
            {redir, dpc_we, cause_we, trap_we, dbg_mode, ebm, illegal}, 0);
        rst = 1'b0;
        cyc("R1");

        // R2: held halt request enters; still held during flush and in mode
        halt_req = 1; pc = 32'h0000_2468;
        cyc("R2"); cyc("R10"); cyc("R9");
        clear_in();
        csr_acc = 1; ebm_we = 1; ebm_wd = 1; hit("R11");
        ebreak = 1; hit("R6");
        ebreak = 1; exc = 1; hit("R7");
        mret = 1; hit("R7");
        nmi = 1; irq = 1; trig_hit = 1; trig_act = 1; hit("R9");
        pc = 32'h0000_3000;
        dret = 1; ecall = 1; hit("R8");
        dret = 1; hit("R8");
        // R3: all three sources at once -> trigger cause
        trig_hit = 1; trig_act = 1; ebreak = 1; halt_req = 1; hit("R3");
        dret = 1; hit("R8");
        trig_hit = 1; trig_act = 0; hit("R3");
        ebreak = 1; halt_req = 1; hit("R3");
        csr_acc = 1; ebm_we = 1; ebm_wd = 0; hit("R11");
        dret = 1; hit("R8");
        // R4: ebreak with ebreakm clear
        ebreak = 1; hit("R4");
        // R5: ranking
        nmi = 1; halt_req = 1; hit("R5");
        irq = 1; halt_req = 1; hit("R5");
        dret = 1; hit("R8");
        irq = 1; exc = 1; hit("R5");
        ecall = 1; hit("R5");
        // R11: access outside mode is illegal and write ignored
        csr_acc = 1; ebm_we = 1; ebm_wd = 1; hit("R11");
        mret = 1; hit("R12");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            halt_req = ($urandom % 100) < 8;
            trig_hit = ($urandom % 100) < 6;
            trig_act = $urandom % 2;
            ebreak   = ($urandom % 100) < 10;
            ecall    = ($urandom % 100) < 5;
            mret     = ($urandom % 100) < 5;
            exc      = ($urandom % 100) < 5;
            dret     = ($urandom % 100) < 15;
            nmi      = ($urandom % 100) < 3;
            irq      = ($urandom % 100) < 6;
            csr_acc  = ($urandom % 100) < 10;
            ebm_we   = ($urandom % 100) < 10;
            ebm_wd   = $urandom % 2;
            pc        = $urandom;
            halt_addr = $urandom;
            exc_addr  = $urandom;
            mtvec     = $urandom;
            nmi_addr  = $urandom;
            cyc("");
        end
        clear_in();
        cyc("");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=finish", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule